// File: doc/BRIEF.md
# Receive FIFO and Interrupt Identification Unit

This unit sits between the serial receiver of an asynchronous serial channel and the processor-facing register file. Each completed character arrives from the deserializer as a byte with three error flags (parity, framing, break) on a one-cycle strobe. The unit queues these entries in a first-in first-out store and presents the oldest one to the register read path. It tracks overrun and accumulated-error conditions, and runs a character timeout that is counted in bit-time ticks.

From those conditions, plus a transmitter-empty level and a modem-change level supplied by neighbouring logic, it builds a prioritized identification byte and a single interrupt request. Software programs a threshold for the data-available condition, selects queued or single-entry operation, and masks the four interrupt classes. Three one-cycle strobes report when the receive data register or the line status register is read, or when the queue is to be flushed.

Top module: `uart_rxq_irq`

## Requirements
- R1: After reset the queue is empty, `data_ready`, `overrun`, `err_any` and `irq` are 0, and `iid` reads 8'h01.
- R2: Entries leave the queue in arrival order, one per `rd_rbr` strobe, and each byte's error flags appear on `head_perr`, `head_ferr` and `head_brk` together with that byte on `rd_data`.
- R3: With queuing on, the data-available condition holds exactly while occupancy is at or above the threshold picked by `trig_sel`: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. It reports as `iid[3:0]` = 4'b0100.
- R4: With queuing on and at least one entry held, `iid[3:0]` becomes 4'b1100 once 4*W+12 bit ticks have passed with no push and no `rd_rbr`. W is the word length, 5 to 8, chosen by `wlen_sel` 00 to 11. It never occurs with the queue empty, and a push or an `rd_rbr` restarts the count.
- R5: Among enabled pending sources, the codes in `iid[3:0]` rank line status 4'b0110 first, then data available 4'b0100, then timeout 4'b1100, then transmitter empty 4'b0010, then modem change 4'b0000.
- R6: `iid[0]` is 1 when no enabled source is pending, and `iid[5:4]` always read 0.
- R7: `ien` bit 0 gates data available and timeout, bit 1 gates transmitter empty, bit 2 gates line status and bit 3 gates modem change. With `ien` all zero, `irq` stays 0 whatever is pending.
- R8: A `rx_clr` strobe empties the queue. A push in the same cycle is discarded, and later entries start from a clean queue.
- R9: `data_ready` is 1 while at least one entry is held and 0 once the queue is empty.
- R10: `err_any` is set by accepting an entry with any error flag and is cleared by `rd_lsr`. The line status source is `overrun` or `err_any`.
- R11: A push into a full queue without a simultaneous read sets `overrun` and leaves the queue contents unchanged. `rd_lsr` clears `overrun`.
- R12: With `fifo_en` = 0 the queue holds one entry, the threshold is 1, no timeout is raised and `iid[7:6]` read 00. With `fifo_en` = 1, `iid[7:6]` read 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push | input | 1 | Character complete strobe (stop-bit center) |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error flag of the byte |
| rx_ferr | input | 1 | Framing error flag of the byte |
| rx_brk | input | 1 | Break flag of the byte |
| bit_tick | input | 1 | One pulse per bit time |
| wlen_sel | input | 2 | Word length select, 00=5 to 11=8 |
| fifo_en | input | 1 | Queued operation enable |
| trig_sel | input | 2 | Data-available threshold select |
| rx_clr | input | 1 | Queue flush strobe |
| ien | input | 4 | Interrupt class enables |
| thr_empty | input | 1 | Transmitter-empty source level |
| mdm_pend | input | 1 | Modem-change source level |
| rd_rbr | input | 1 | Receive data register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_data | output | 8 | Oldest queued byte |
| head_perr | output | 1 | Parity flag of the oldest entry |
| head_ferr | output | 1 | Framing flag of the oldest entry |
| head_brk | output | 1 | Break flag of the oldest entry |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky overrun flag |
| err_any | output | 1 | Sticky error-in-queue flag |
| iid | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |

## Verification
The threshold logic is exercised for all four `trig_sel` values by filling to one below the level and then to the level. This separates an off-by-one compare from a wrong threshold table. The timeout is run for the shortest and longest word lengths, stopping one tick short and then one tick on, and a separate sequence interleaves pushes and reads to show that both restart the count. The priority sequence raises modem, transmitter, data, error and timeout sources in an order where each new code differs from the last. Full-queue, flush and single-entry sequences distinguish dropped bytes from overwritten ones.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_ent_t;

  typedef enum logic [3:0] {
    ID_NONE = 4'b0001,
    ID_LINE = 4'b0110,
    ID_RDA  = 4'b0100,
    ID_TMO  = 4'b1100,
    ID_THRE = 4'b0010,
    ID_MDM  = 4'b0000
  } iid_e;

  // Data-available threshold in entries.
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Timeout length in bit times: four per data bit plus twelve.
  function automatic int tmo_bits(input logic [1:0] wsel);
    return 4 * (5 + int'(wsel)) + 12;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] cap,
  input  rx_ent_t       wdata,
  output rx_ent_t       rdata,
  output logic [CW-1:0] occ,
  output logic          push_ok,
  output logic          ovr_evt
);

  rx_ent_t       mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          pop_ok, full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (occ >= cap);
  assign pop_ok  = pop && (occ != '0) && !clr;
  assign push_ok = push && !clr && (!full || pop_ok);
  assign ovr_evt = push && !clr && full && !pop_ok;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      unique case ({push_ok, pop_ok})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          armed,
  input  logic [LW-1:0] limit,
  output logic          pend
);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart || !armed)       cnt <= '0;
    else if (tick && (cnt != limit))  cnt <= cnt + LW'(1);
  end

  assign pend = armed && (cnt == limit);

endmodule

// File: rtl/rxq_idcode.sv
module rxq_idcode
  import rxq_pkg::*;
(
  input  logic       fifo_en,
  input  logic [3:0] ien,
  input  logic       ls,
  input  logic       rda,
  input  logic       tmo,
  input  logic       thre,
  input  logic       mdm,
  output logic [7:0] iid,
  output logic       irq
);

  iid_e code;

  // Later assignments take precedence: lowest priority first.
  always_comb begin
    code = ID_NONE;
    if (ien[3] && mdm)  code = ID_MDM;
    if (ien[1] && thre) code = ID_THRE;
    if (ien[0] && tmo)  code = ID_TMO;
    if (ien[0] && rda)  code = ID_RDA;
    if (ien[2] && ls)   code = ID_LINE;
  end

  assign iid = {fifo_en, fifo_en, 2'b00, code};
  assign irq = |(ien & {mdm, ls, thre, rda | tmo});

endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_push,
  input  logic [7:0] rx_byte,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       bit_tick,
  input  logic [1:0] wlen_sel,
  input  logic       fifo_en,
  input  logic [1:0] trig_sel,
  input  logic       rx_clr,
  input  logic [3:0] ien,
  input  logic       thr_empty,
  input  logic       mdm_pend,
  input  logic       rd_rbr,
  input  logic       rd_lsr,
  output logic [7:0] rd_data,
  output logic       head_perr,
  output logic       head_ferr,
  output logic       head_brk,
  output logic       data_ready,
  output logic       overrun,
  output logic       err_any,
  output logic [7:0] iid,
  output logic       irq
);

  localparam int CW = $clog2(DEPTH) + 1;

  rx_ent_t       wr_ent, hd_ent;
  logic [CW-1:0] occ, cap, trig;
  logic          push_ok, ovr_evt, err_evt;
  logic          rda_cond, tmo_cond, ls_cond;

  assign wr_ent = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_byte};
  assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  assign trig   = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (rx_clr),
    .push   (rx_push),
    .pop    (rd_rbr),
    .cap    (cap),
    .wdata  (wr_ent),
    .rdata  (hd_ent),
    .occ    (occ),
    .push_ok(push_ok),
    .ovr_evt(ovr_evt)
  );

  assign data_ready = (occ != '0);
  assign rd_data    = hd_ent.data;
  assign head_perr  = data_ready && hd_ent.perr;
  assign head_ferr  = data_ready && hd_ent.ferr;
  assign head_brk   = data_ready && hd_ent.brk;
  assign rda_cond   = (occ >= trig);

  rxq_timeout #(.LW(LW)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (bit_tick),
    .restart(rx_push || rd_rbr || rx_clr),
    .armed  (fifo_en && data_ready),
    .limit  (LW'(tmo_bits(wlen_sel))),
    .pend   (tmo_cond)
  );

  assign err_evt = push_ok && (rx_perr || rx_ferr || rx_brk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      err_any <= 1'b0;
    end else begin
      if (ovr_evt)     overrun <= 1'b1;
      else if (rd_lsr) overrun <= 1'b0;
      if (err_evt)     err_any <= 1'b1;
      else if (rd_lsr) err_any <= 1'b0;
    end
  end

  assign ls_cond = overrun || err_any;

  rxq_idcode u_id (
    .fifo_en(fifo_en),
    .ien    (ien),
    .ls     (ls_cond),
    .rda    (rda_cond),
    .tmo    (tmo_cond),
    .thre   (thr_empty),
    .mdm    (mdm_pend),
    .iid    (iid),
    .irq    (irq)
  );

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic          rx_clr,
  input logic          rd_lsr,
  input logic          fifo_en,
  input logic [3:0]    ien,
  input logic [7:0]    iid,
  input logic          irq,
  input logic          data_ready,
  input logic          overrun,
  input logic          err_any,
  input logic [CW-1:0] occ,
  input logic          ovr_evt
);

  // R7
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'b0000) |-> !irq);

  // R6
  reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iid[5:4] == 2'b00);

  // R12
  single_mode_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (iid[7:6] == 2'b00));

  // R4
  no_timeout_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> (iid[3:0] != 4'b1100));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> !data_ready);

  // R11
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> overrun);

  // R10
  lsr_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !rx_push) |=> (!err_any && !overrun));

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

endmodule

bind uart_rxq_irq rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_push   (rx_push),
  .rx_clr    (rx_clr),
  .rd_lsr    (rd_lsr),
  .fifo_en   (fifo_en),
  .ien       (ien),
  .iid       (iid),
  .irq       (irq),
  .data_ready(data_ready),
  .overrun   (overrun),
  .err_any   (err_any),
  .occ       (occ),
  .ovr_evt   (ovr_evt)
);

// File: tb/tb_uart_rxq_irq.sv
module tb_uart_rxq_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_push = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       bit_tick = 1'b0, fifo_en = 1'b0, rx_clr = 1'b0;
  logic [1:0] wlen_sel = 2'b00, trig_sel = 2'b00;
  logic [3:0] ien = 4'b0000;
  logic       thr_empty = 1'b0, mdm_pend = 1'b0, rd_rbr = 1'b0, rd_lsr = 1'b0;
  logic [7:0] rd_data, iid;
  logic       head_perr, head_ferr, head_brk, data_ready, overrun, err_any, irq;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rxq_irq dut (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .bit_tick(bit_tick),
    .wlen_sel(wlen_sel), .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_clr(rx_clr),
    .ien(ien), .thr_empty(thr_empty), .mdm_pend(mdm_pend), .rd_rbr(rd_rbr),
    .rd_lsr(rd_lsr), .rd_data(rd_data), .head_perr(head_perr), .head_ferr(head_ferr),
    .head_brk(head_brk), .data_ready(data_ready), .overrun(overrun),
    .err_any(err_any), .iid(iid), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic [2:0] e);
    rx_byte = b; {rx_brk, rx_ferr, rx_perr} = e; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
  endtask

  task automatic read_rbr(output logic [7:0] b, output logic [2:0] e);
    b = rd_data; e = {head_brk, head_ferr, head_perr}; rd_rbr = 1'b1;
    @(negedge clk);
    rd_rbr = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; end
  endtask

  task automatic flush();
    rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
  endtask

  task automatic lsr_read();
    rd_lsr = 1'b1; @(negedge clk); rd_lsr = 1'b0;
  endtask

  function automatic int tmo_len(input int w);
    return 12 + w * 4;
  endfunction

  task automatic t_reset();
    chk("R1 iid", iid, 8'h01);
    chk("R1 irq", irq, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 err_any", err_any, 0);
  endtask

  task automatic t_order();
    logic [7:0] b; logic [2:0] e;
    logic [7:0] vals [5] = '{8'h10, 8'hA5, 8'h3C, 8'hFF, 8'h00};
    logic [2:0] errs [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b000};
    fifo_en = 1'b1; ien = 4'b0000; flush();
    chk("R6 iid fifo on idle", iid, 8'hC1);
    foreach (vals[i]) push(vals[i], errs[i]);
    chk("R9 data_ready", data_ready, 1);
    chk("R10 err_any set", err_any, 1);
    foreach (vals[i]) begin
      read_rbr(b, e);
      chk("R2 byte order", b, vals[i]);
      chk("R2 flags follow byte", e, errs[i]);
    end
    chk("R9 empty after reads", data_ready, 0);
    chk("R10 err_any sticky", err_any, 1);
    lsr_read();
    chk("R10 err_any cleared", err_any, 0);
  endtask

  task automatic t_trigger();
    logic [7:0] b; logic [2:0] e;
    int lv [4] = '{1, 4, 8, 14};
    ien = 4'b0001;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s); flush();
      for (int k = 0; k < lv[s] - 1; k++) push(8'(k), 3'b000);
      chk("R3 below threshold", iid, 8'hC1);
      push(8'h77, 3'b000);
      chk("R3 at threshold", iid, 8'hC4);
      chk("R3 irq", irq, 1);
      read_rbr(b, e);
      chk("R3 drops below", iid, 8'hC1);
    end
    flush();
  endtask

  task automatic t_timeout();
    logic [7:0] b; logic [2:0] e;
    int ws [2] = '{0, 3};
    ien = 4'b0001; trig_sel = 2'b11;
    foreach (ws[i]) begin
      wlen_sel = 2'(ws[i]); flush();
      push(8'h42, 3'b000);
      ticks(tmo_len(5 + ws[i]) - 1);
      chk("R4 one tick short", iid, 8'hC1);
      ticks(1);
      chk("R4 timeout code", iid, 8'hCC);
      chk("R4 timeout irq", irq, 1);
      read_rbr(b, e);
      chk("R4 cleared by read", iid, 8'hC1);
    end
    wlen_sel = 2'b10; flush();
    push(8'h01, 3'b000); push(8'h02, 3'b000);
    ticks(tmo_len(7) - 1);
    push(8'h03, 3'b000);
    ticks(tmo_len(7) - 1);
    chk("R4 push restarts", iid, 8'hC1);
    read_rbr(b, e);
    ticks(tmo_len(7) - 1);
    chk("R4 read restarts", iid, 8'hC1);
    ticks(1);
    chk("R4 timeout after restart", iid, 8'hCC);
    flush();
    ticks(60);
    chk("R4 none when empty", iid, 8'hC1);
  endtask

  task automatic t_priority();
    logic [7:0] b; logic [2:0] e;
    ien = 4'b1111; trig_sel = 2'b00; wlen_sel = 2'b00; flush(); lsr_read();
    thr_empty = 1'b1; mdm_pend = 1'b1; @(negedge clk);
    chk("R5 thre over modem", iid, 8'hC2);
    thr_empty = 1'b0; @(negedge clk);
    chk("R5 modem code", iid, 8'hC0);
    chk("R7 modem irq", irq, 1);
    push(8'h11, 3'b000);
    chk("R5 data over modem", iid, 8'hC4);
    push(8'h22, 3'b001);
    chk("R5 line status first", iid, 8'hC6);
    lsr_read();
    chk("R5 back to data", iid, 8'hC4);
    trig_sel = 2'b01; @(negedge clk);
    chk("R5 below trigger modem", iid, 8'hC0);
    ticks(tmo_len(5) - 1);
    ticks(1);
    chk("R5 timeout over modem", iid, 8'hCC);
    read_rbr(b, e);
    chk("R4 read clears timeout", iid, 8'hC0);
    mdm_pend = 1'b0; @(negedge clk);
    chk("R6 none pending", iid, 8'hC1);
    flush();
  endtask

  task automatic t_polled();
    ien = 4'b0000; thr_empty = 1'b1; mdm_pend = 1'b1; trig_sel = 2'b00;
    push(8'h99, 3'b010);
    chk("R7 masked irq", irq, 0);
    chk("R7 masked iid", iid, 8'hC1);
    ien = 4'b0010; @(negedge clk);
    chk("R7 thre enable only", iid, 8'hC2);
    thr_empty = 1'b0; mdm_pend = 1'b0; ien = 4'b0000;
    flush(); lsr_read();
  endtask

  task automatic t_overrun();
    logic [7:0] b; logic [2:0] e;
    ien = 4'b0100; flush();
    for (int k = 0; k < 16; k++) push(8'(k * 3 + 1), 3'b000);
    chk("R11 no overrun at full", overrun, 0);
    chk("R10 no line status", iid, 8'hC1);
    push(8'hEE, 3'b000);
    chk("R11 overrun set", overrun, 1);
    chk("R10 overrun line status", iid, 8'hC6);
    for (int k = 0; k < 16; k++) begin
      read_rbr(b, e);
      chk("R11 contents unchanged", b, 8'(k * 3 + 1));
    end
    chk("R9 empty", data_ready, 0);
    lsr_read();
    chk("R11 overrun cleared", overrun, 0);
    chk("R10 line status gone", iid, 8'hC1);
  endtask

  task automatic t_flush();
    logic [7:0] b; logic [2:0] e;
    push(8'h01, 3'b000); push(8'h02, 3'b000); push(8'h03, 3'b000);
    flush();
    chk("R8 flushed", data_ready, 0);
    push(8'h5A, 3'b000);
    read_rbr(b, e);
    chk("R8 fresh after flush", b, 8'h5A);
    rx_byte = 8'h66; rx_push = 1'b1; rx_clr = 1'b1;
    @(negedge clk);
    rx_push = 1'b0; rx_clr = 1'b0;
    chk("R8 push with flush dropped", data_ready, 0);
  endtask

  task automatic t_single();
    logic [7:0] b; logic [2:0] e;
    flush(); lsr_read();
    fifo_en = 1'b0; ien = 4'b0001; trig_sel = 2'b11;
    push(8'h31, 3'b000);
    chk("R12 threshold one", iid, 8'h04);
    push(8'h32, 3'b000);
    chk("R12 capacity one", overrun, 1);
    ticks(60);
    chk("R12 no timeout", iid, 8'h04);
    read_rbr(b, e);
    chk("R12 first kept", b, 8'h31);
    chk("R12 idle code", iid, 8'h01);
    lsr_read();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger();
    t_timeout();
    t_priority();
    t_polled();
    t_overrun();
    t_flush();
    t_single();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule